// File: doc/BRIEF.md
# Ternary Strap Pin Reader

This block reads a set of board-identification strap pins. Each pin can carry one of three values: tied low, tied high or left unconnected. After a start pulse, the sequencer visits the pins one at a time in index order.

For each pin, it takes the pin away from its normal function by raising a per-pin probe line. It then turns on the pin's weak internal pull-up, waits a settling interval, and samples the synchronised pad level. Next it swaps to the weak internal pull-down, waits the same interval, and samples again. If both samples agree, the pin is externally driven to that level. If the samples disagree, the pin follows the internal pull and is therefore unconnected.

The per-pin digits are folded into one base-3 code, with pin 0 as the most significant digit. When the last pin is finished, a one-cycle done pulse marks the code as ready.

Each pin's pull state is kept in the block between runs. In the normal mode, a driven pin is left with no pull and an unconnected pin is left pulled down, so that it draws no current. In preserve mode, the pull state a pin had just before it was probed is put back. The settling interval is given in nanoseconds and converted to clock cycles at elaboration.

Top module: `strap_ternary_reader`

## Requirements
- R1: After reset, done_o, result_o, probe_o, pull_up_o and pull_dn_o are all zero.
- R2: Pins are probed in index order 0 to NUM_PINS-1. While pin k is probed, probe_o has only bit k set. During probing, pull_up_o[k] is high for the first settling interval and pull_dn_o[k] is high for the second. When the block is idle, probe_o is zero.
- R3: A pin's digit is 1 when both samples are high and 0 when both are low. It is 2 when the pull-up sample and the pull-down sample differ, in either order.
- R4: result_o equals the sum over k of digit(k)·3^(NUM_PINS-1-k), so pin 0 is the most significant base-3 digit. The value never reaches 3^NUM_PINS.
- R5: done_o is high for exactly one cycle. It rises NUM_PINS·(1+2·S) clock edges after the edge that accepts start_i, where S is the settling interval in cycles. result_o then holds until the next accepted start.
- R6: A start_i pulse while a scan is in progress has no effect on timing, on the result or on the pull outputs.
- R7: With preserve_i low when the scan starts, each driven pin ends with both pulls off, and each unconnected pin ends with only pull_dn_o set.
- R8: With preserve_i high when the scan starts, every pin's pull_up_o and pull_dn_o return to the values they had before the scan.
- R9: S equals CLK_HZ·SETTLE_NS/10^9 rounded up. The pad inputs pass through a two-stage synchronizer. The configuration is rejected at elaboration when S does not exceed the synchronizer depth, or when NUM_PINS lies outside 1 to 8.
- R10: At most one probe_o bit is high, and no pin ever has pull_up_o and pull_dn_o high at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| preserve_i | input | 1 | Restore pull state after probing (latched at start) |
| pad_i | input | NUM_PINS | Pad levels of the strap pins, asynchronous |
| probe_o | output | NUM_PINS | Forces the pin into input mode while it is probed |
| pull_up_o | output | NUM_PINS | Weak internal pull-up enable per pin |
| pull_dn_o | output | NUM_PINS | Weak internal pull-down enable per pin |
| done_o | output | 1 | One-cycle pulse when result_o is complete |
| result_o | output | RES_W | Base-3 strap code |

## Verification
The assertions assume that an externally driven pad holds its level for the whole of a pin's probe. They also assume that an unconnected pad settles to the active pull within the settling interval, so that the synchronised samples reflect the pin's state. The bench models every pad as tied low, tied high, following the pull-up, or following the pull-down inversely. It changes the pad models only between scans. Start pulses always last one cycle, and the one issued mid-scan falls well inside the scan.

// File: rtl/strap_pkg.sv
package strap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SET_UP,
      ST_WAIT_HI,
      ST_WAIT_LO,
      ST_DONE
   } strap_state_e;

   localparam logic [1:0] DIG_LOW  = 2'd0;
   localparam logic [1:0] DIG_HIGH = 2'd1;
   localparam logic [1:0] DIG_OPEN = 2'd2;

   function automatic int pow3(input int n);
      int r;
      r = 1;
      for (int i = 0; i < n; i++) r = r * 3;
      return r;
   endfunction

   function automatic logic [1:0] classify(input logic s_up, input logic s_dn);
      if (s_up && s_dn)        return DIG_HIGH;
      else if (!s_up && !s_dn) return DIG_LOW;
      else                     return DIG_OPEN;
   endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
   parameter int CYCLES = 1875
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expired_o
);

   localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load_i)       cnt <= TW'(CYCLES - 1);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired_o = (cnt == '0);

   AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) <= CYCLES - 1);                                   // R9
   AST_TIMER_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));     // R9

endmodule

// File: rtl/strap_digit_acc.sv
module strap_digit_acc
   import strap_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int RES_W    = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             push_i,
   input  logic [1:0]       digit_i,
   output logic [RES_W-1:0] acc_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_o <= '0;
      else if (clear_i) acc_o <= '0;
      else if (push_i)  acc_o <= RES_W'(acc_o * RES_W'(3)) + RES_W'(digit_i);
   end

   AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (digit_i != 2'd3));                              // R3
   AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(acc_o) < pow3(NUM_PINS));                              // R4

endmodule

// File: rtl/strap_ternary_reader.sv
module strap_ternary_reader
   import strap_pkg::*;
#(
   parameter int          NUM_PINS    = 8,
   parameter int unsigned CLK_HZ      = 125_000_000,
   parameter int unsigned SETTLE_NS   = 15_000,
   parameter int          SYNC_STAGES = 2,
   parameter int          RES_W       = $clog2(pow3(NUM_PINS))
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                preserve_i,
   input  logic [NUM_PINS-1:0] pad_i,
   output logic [NUM_PINS-1:0] probe_o,
   output logic [NUM_PINS-1:0] pull_up_o,
   output logic [NUM_PINS-1:0] pull_dn_o,
   output logic                done_o,
   output logic [RES_W-1:0]    result_o
);

   localparam longint unsigned SETTLE_L =
      (64'(CLK_HZ) * 64'(SETTLE_NS) + 64'd999_999_999) / 64'd1_000_000_000;
   localparam int SETTLE_CYC = int'(SETTLE_L);
   localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   // elaboration-time parameter checks (R9)
   if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
      $error("NUM_PINS must be within 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SETTLE_CYC <= SYNC_STAGES) begin : g_bad_settle
      $error("settling interval must exceed synchronizer depth");
   end
   if ((64'd1 << RES_W) < 64'(pow3(NUM_PINS))) begin : g_bad_resw
      $error("RES_W too narrow for 3^NUM_PINS - 1");
   end

   strap_state_e        state;
   logic [IDX_W-1:0]    idx;
   logic                keep_q;
   logic                hi_q;
   logic                saved_pu, saved_pd;
   logic [NUM_PINS-1:0] pu_q, pd_q, probe_q;
   logic [NUM_PINS-1:0] pad_s;
   logic                expired, tmr_load, push, clear;
   logic [1:0]          digit;
   logic                last_pin;

   strap_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_i),
      .q_o   (pad_s)
   );

   assign tmr_load = (state == ST_SET_UP) || (state == ST_WAIT_HI && expired);

   strap_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .expired_o (expired)
   );

   assign digit    = classify(hi_q, pad_s[idx]);
   assign push     = (state == ST_WAIT_LO) && expired;
   assign clear    = (state == ST_IDLE) && start_i;
   assign last_pin = (idx == IDX_W'(NUM_PINS - 1));

   strap_digit_acc #(.NUM_PINS(NUM_PINS), .RES_W(RES_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .push_i  (push),
      .digit_i (digit),
      .acc_o   (result_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         keep_q   <= 1'b0;
         hi_q     <= 1'b0;
         saved_pu <= 1'b0;
         saved_pd <= 1'b0;
         pu_q     <= '0;
         pd_q     <= '0;
         probe_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  keep_q <= preserve_i;
                  idx    <= '0;
                  state  <= ST_SET_UP;
               end
            end
            ST_SET_UP: begin
               saved_pu       <= pu_q[idx];
               saved_pd       <= pd_q[idx];
               pu_q[idx]      <= 1'b1;
               pd_q[idx]      <= 1'b0;
               probe_q        <= '0;
               probe_q[idx]   <= 1'b1;
               state          <= ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
               if (expired) begin
                  hi_q      <= pad_s[idx];
                  pu_q[idx] <= 1'b0;
                  pd_q[idx] <= 1'b1;
                  state     <= ST_WAIT_LO;
               end
            end
            ST_WAIT_LO: begin
               if (expired) begin
                  probe_q <= '0;
                  if (keep_q) begin
                     pu_q[idx] <= saved_pu;
                     pd_q[idx] <= saved_pd;
                  end else if (digit != DIG_OPEN) begin
                     pd_q[idx] <= 1'b0;
                  end
                  if (last_pin) state <= ST_DONE;
                  else begin
                     idx   <= idx + 1'b1;
                     state <= ST_SET_UP;
                  end
               end
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign probe_o   = probe_q;
   assign pull_up_o = pu_q;
   assign pull_dn_o = pd_q;
   assign done_o    = (state == ST_DONE);

   AST_PROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(probe_o));                                          // R10
   AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up_o & pull_dn_o) == '0);                              // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                         // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (probe_o == '0));                     // R2
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state != ST_IDLE && state != ST_DONE) |=> (state != ST_IDLE)); // R6
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start_i) |=> $stable(result_o));       // R5

endmodule

// File: tb/tb_strap_ternary_reader.sv
module tb_strap_ternary_reader;

   localparam int NP  = 8;
   localparam int S   = 25;          // 200 ns at 125 MHz, rounded up
   localparam int RW  = 13;
   localparam int LAT = NP * (1 + 2 * S);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          preserve_i = 1'b0;
   logic [NP-1:0] pad_i;
   logic [NP-1:0] probe_o, pull_up_o, pull_dn_o;
   logic          done_o;
   logic [RW-1:0] result_o;

   // pad model per pin: 0 tied low, 1 tied high, 2 follows pull-up, 3 inverse of pull
   logic [1:0] pmode [NP];

   int n_checks = 0;
   int n_fail   = 0;
   int up0_cnt, dn0_cnt, upl_cnt, dnl_cnt;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         case (pmode[i])
            2'd0:    pad_i[i] = 1'b0;
            2'd1:    pad_i[i] = 1'b1;
            2'd2:    pad_i[i] = pull_up_o[i];
            default: pad_i[i] = pull_dn_o[i];
         endcase
      end
   end

   always @(negedge clk) begin
      if (probe_o[0] && pull_up_o[0])       up0_cnt++;
      if (probe_o[0] && pull_dn_o[0])       dn0_cnt++;
      if (probe_o[NP-1] && pull_up_o[NP-1]) upl_cnt++;
      if (probe_o[NP-1] && pull_dn_o[NP-1]) dnl_cnt++;
   end

   strap_ternary_reader #(
      .NUM_PINS (NP),
      .CLK_HZ   (125_000_000),
      .SETTLE_NS(200)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .preserve_i(preserve_i),
      .pad_i     (pad_i),
      .probe_o   (probe_o),
      .pull_up_o (pull_up_o),
      .pull_dn_o (pull_dn_o),
      .done_o    (done_o),
      .result_o  (result_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_digit(input logic [1:0] m);
      return (m == 2'd0) ? 0 : (m == 2'd1) ? 1 : 2;
   endfunction

   // one full scan with its own checks
   task automatic run_scan(input bit keep, input bit poke_busy);
      int            expv, cnt;
      logic [NP-1:0] pu_before, pd_before, exp_pd;
      logic [RW-1:0] held;
      expv = 0;
      exp_pd = '0;
      for (int i = 0; i < NP; i++) begin
         expv = expv * 3 + exp_digit(pmode[i]);
         if (exp_digit(pmode[i]) == 2) exp_pd[i] = 1'b1;
      end
      @(negedge clk);
      pu_before = pull_up_o;
      pd_before = pull_dn_o;
      up0_cnt = 0; dn0_cnt = 0; upl_cnt = 0; dnl_cnt = 0;
      preserve_i = keep;
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      preserve_i = 1'b0;
      cnt = 0;
      while (!done_o && cnt < LAT + 50) begin
         @(negedge clk);
         cnt++;
         start_i = poke_busy && (cnt == 60);
      end
      start_i = 1'b0;
      check(cnt == LAT, "R5 latency", cnt, LAT);
      if (poke_busy) check(cnt == LAT, "R6 busy start timing", cnt, LAT);
      check(result_o == RW'(expv), "R4/R3 result", result_o, expv);
      check(up0_cnt == S && dn0_cnt == S, "R2/R9 pin0 pull windows", up0_cnt * 1000 + dn0_cnt, S * 1000 + S);
      check(upl_cnt == S && dnl_cnt == S, "R2 last pin pull windows", upl_cnt * 1000 + dnl_cnt, S * 1000 + S);
      held = result_o;
      @(negedge clk);
      check(done_o == 1'b0, "R5 done one cycle", done_o, 0);
      check(probe_o == '0, "R2 probe idle", probe_o, 0);
      if (keep) begin
         check(pull_up_o == pu_before, "R8 pull-up restored", pull_up_o, pu_before);
         check(pull_dn_o == pd_before, "R8 pull-down restored", pull_dn_o, pd_before);
      end else begin
         check(pull_up_o == '0, "R7 pull-ups off", pull_up_o, 0);
         check(pull_dn_o == exp_pd, "R7 park pull-downs", pull_dn_o, exp_pd);
      end
      repeat (5) @(negedge clk);
      check(result_o == held, "R5 result held", result_o, held);
   endtask

   task automatic t_reset();
      check(done_o == 1'b0 && result_o == '0, "R1 done/result", {done_o, result_o}, 0);
      check(probe_o == '0 && pull_up_o == '0 && pull_dn_o == '0, "R1 pins",
            {probe_o, pull_up_o, pull_dn_o}, 0);
   endtask

   task automatic set_all(input logic [1:0] m);
      for (int i = 0; i < NP; i++) pmode[i] = m;
   endtask

   task automatic t_all_low();   set_all(2'd0); run_scan(1'b0, 1'b0); endtask
   task automatic t_all_high();  set_all(2'd1); run_scan(1'b0, 1'b0); endtask
   task automatic t_all_open();  set_all(2'd2); run_scan(1'b0, 1'b0); endtask

   task automatic t_mixed();     // R4 digit order, R3 inverse-follow case
      pmode[0] = 2'd1; pmode[1] = 2'd0; pmode[2] = 2'd2; pmode[3] = 2'd3;
      pmode[4] = 2'd1; pmode[5] = 2'd2; pmode[6] = 2'd0; pmode[7] = 2'd1;
      run_scan(1'b0, 1'b0);
   endtask

   task automatic t_busy_start(); // R6
      pmode[0] = 2'd0; pmode[1] = 2'd2; pmode[2] = 2'd1; pmode[3] = 2'd1;
      pmode[4] = 2'd3; pmode[5] = 2'd0; pmode[6] = 2'd2; pmode[7] = 2'd0;
      run_scan(1'b0, 1'b1);
   endtask

   task automatic t_preserve();   // R8 after a parking run leaves pull-downs set
      pmode[0] = 2'd2; pmode[1] = 2'd1; pmode[2] = 2'd2; pmode[3] = 2'd0;
      pmode[4] = 2'd2; pmode[5] = 2'd1; pmode[6] = 2'd0; pmode[7] = 2'd2;
      run_scan(1'b0, 1'b0);
      set_all(2'd1);
      run_scan(1'b1, 1'b0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      set_all(2'd0);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_all_low();
      t_all_high();
      t_all_open();
      t_mixed();
      t_busy_start();
      t_preserve();
      finish_run();
   end

   initial begin
      #(8 * 200_000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule